// File: doc/BRIEF.md
# Programmable Clock Source Divider

This block derives one output clock from a set of seven candidate clock inputs. A 16-bit control word picks the source, optionally inverts it, and divides it by a 6-bit integer. The result is driven out behind an output enable. Software reaches the control word through a plain write strobe with a combinational read-back. The candidate clocks are handled as data: each one is brought into the block's own `clk` domain through a short synchronizer chain. Division works by counting rising edges of the selected, possibly inverted, source. For that reason every phase of a source must last at least one `clk` period.

A divisor change normally waits for the end of the current output period, so the output never shows a shortened or stretched pulse. Setting the load-now pulse bit in the same write applies the new value at once and restarts the count. A divider-run bit holds the counter cleared and the output low while it is 0. A presence flag is stored and reflected on a status pin.

Field layout of the control word: divisor [5:0], load-now [6], invert [7], source select [10:8], output enable [11], present [12], divider run [13], reserved [15:14]. In passthrough mode (divisor 0 or 1), the output follows the selected source `SYNC_STAGES + 3` clk cycles later.

Top module: `clksrc_divider`

## Requirements
- R1: After reset `rd_data` reads 0x0403. After a write, `rd_data` returns the written word with bits 15:14 and bit 6 (load-now) reading as 0, and every other bit as written.
- R2: Source select code k in 0..6 (bits 10:8) picks `src_in[k]`: bits 0..2 are the three transmit clocks, bits 3..5 the three receive clocks, bit 6 the memory clock.
- R3: A divisor of 0 or 1 passes the selected source through undivided, so the output has the source's own high and low durations.
- R4: A divisor N of 2 or more gives an output period of N source periods. The output is high for floor(N/2) periods and low for the rest, counted on the rising edges of the selected source.
- R5: An odd divisor is not evened out to 50-50. The output is high for (N-1)/2 source periods and low for (N+1)/2.
- R6: With the invert bit (bit 7) set, the selected source is complemented before it reaches the divider or the passthrough path.
- R7: Without load-now, a new divisor takes effect only when the current output period ends. The period in progress completes at the old length.
- R8: Writing load-now (bit 6) as 1 together with a divisor applies that divisor at once and restarts the count from the start of a period.
- R9: While the divider-run bit (bit 13) is 0, the counter is held cleared and `clk_out` stays low.
- R10: When the output enable (bit 11) is 0, `clk_oe` is 0 and `clk_out` stays low.
- R11: A reserved source code (7) holds `clk_out` low regardless of divisor or invert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all logic samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word (reserved and pulse bits read 0) |
| src_in | input | 7 | Candidate clock inputs, sampled into the clk domain |
| clk_out | output | 1 | Derived clock, registered |
| clk_oe | output | 1 | Output-enable, active high, for the pad driver |
| clk_present | output | 1 | Stored presence flag from bit 12 |

## Verification
The assertions take for granted that reset is held for at least one `clk` edge before use, and that `wr_en` is a single-cycle strobe. They also expect every phase of each source to last at least one `clk` period, so that every source edge is seen as a one-cycle rising event after the synchronizer. The stimulus drives each `src_in` bit from a free-running generator with a high phase of one to seven cycles and a low phase of seven cycles. It issues writes only between edges, one cycle at a time. Measurements start only after a settling window long enough for any pending divisor to reach the end of its period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CW     = 16;
  localparam int DIV_W  = 6;
  localparam int SEL_W  = 3;

  localparam int DIV_LSB  = 0;
  localparam int LOAD_BIT = 6;
  localparam int INV_BIT  = 7;
  localparam int SEL_LSB  = 8;
  localparam int OE_BIT   = 11;
  localparam int PRES_BIT = 12;
  localparam int RUN_BIT  = 13;

  localparam logic [CW-1:0] CTRL_RESET = 16'h0403;
  localparam logic [CW-1:0] CTRL_WMASK = 16'h3FBF;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             inv;
    logic [SEL_W-1:0] sel;
    logic             oe;
    logic             pres;
    logic             run;
  } ctrl_fields_t;

  function automatic ctrl_fields_t unpack_ctrl(input logic [CW-1:0] w);
    ctrl_fields_t f;
    f.div  = w[DIV_LSB +: DIV_W];
    f.inv  = w[INV_BIT];
    f.sel  = w[SEL_LSB +: SEL_W];
    f.oe   = w[OE_BIT];
    f.pres = w[PRES_BIT];
    f.run  = w[RUN_BIT];
    return f;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctrl_q,
  output logic          ld_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RESET;
      ld_pulse <= 1'b0;
    end else begin
      ld_pulse <= wr_en & wr_data[LOAD_BIT];
      if (wr_en) ctrl_q <= wr_data & CTRL_WMASK;
    end
  end

  // R1: a write lands with reserved and pulse bits cleared
  a_r1_write_mask: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q == ($past(wr_data) & CTRL_WMASK)));

  // R8: the load pulse appears only right after a write carrying it
  a_r8_pulse_origin: assert property (@(posedge clk) disable iff (rst)
    ld_pulse |-> $past(wr_en));
endmodule

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel
  import clkdiv_pkg::*;
#(
  parameter int N_SRC       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             src_q
);
  localparam logic [SEL_W:0] NUM_SRC = (SEL_W+1)'(N_SRC);

  logic [N_SRC-1:0] synced;

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], src_in[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  logic pick;
  logic sel_ok;

  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel == SEL_W'(k)) pick = synced[k];
    end
  end

  assign sel_ok = ({1'b0, sel} < NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst)         src_q <= 1'b0;
    else if (sel_ok) src_q <= pick ^ inv;
    else             src_q <= 1'b0;
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             src,
  input  logic             run,
  input  logic             ld,
  input  logic [DIV_W-1:0] div_field,
  output logic             core_out
);
  localparam logic [DIV_W-1:0] DIV_RESET = CTRL_RESET[DIV_LSB +: DIV_W];

  logic             src_prev;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_act_q;
  logic             rise;
  logic             pass;
  logic             pass_new;
  logic             wrap;
  logic [DIV_W-1:0] half;

  assign rise     = src & ~src_prev;
  assign pass     = (div_act_q <= DIV_W'(1));
  assign pass_new = (div_field <= DIV_W'(1));
  assign half     = div_act_q >> 1;
  assign wrap     = rise & (pass | (cnt_q == (div_act_q - DIV_W'(1))));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev  <= 1'b0;
      cnt_q     <= '0;
      div_act_q <= DIV_RESET;
      core_out  <= 1'b0;
    end else begin
      src_prev <= src;
      if (!run) begin
        cnt_q     <= '0;
        div_act_q <= div_field;
        core_out  <= 1'b0;
      end else if (ld) begin
        cnt_q     <= '0;
        div_act_q <= div_field;
        core_out  <= pass_new ? src : 1'b1;
      end else begin
        if (wrap) begin
          cnt_q     <= '0;
          div_act_q <= div_field;
        end else if (rise) begin
          cnt_q <= cnt_q + DIV_W'(1);
        end
        core_out <= pass ? src : (cnt_q < half);
      end
    end
  end

  // R9: a stopped divider is cleared and quiet one cycle later
  a_r9_hold_clear: assert property (@(posedge clk) disable iff (rst)
    !run |=> ((cnt_q == '0) && !core_out));

  // R7: without a load pulse the active divisor moves only at a period end
  a_r7_safe_switch: assert property (@(posedge clk) disable iff (rst)
    ((div_act_q != $past(div_act_q)) && $past(run) && !$past(ld)) |-> $past(wrap));

  // R4: the count never leaves the active period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (run && !pass) |-> (cnt_q < div_act_q));
endmodule

// File: rtl/clksrc_divider.sv
module clksrc_divider
  import clkdiv_pkg::*;
#(
  parameter int N_SRC       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic [N_SRC-1:0] src_in,
  output logic             clk_out,
  output logic             clk_oe,
  output logic             clk_present
);
  localparam logic [SEL_W:0] NUM_SRC = (SEL_W+1)'(N_SRC);

  logic [CW-1:0] ctrl_q;
  logic          ld_pulse;
  ctrl_fields_t  f;
  logic          src_q;
  logic          core_out;
  logic          sel_ok;

  clkdiv_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .ld_pulse (ld_pulse)
  );

  assign f = unpack_ctrl(ctrl_q);

  clkdiv_src_sel #(
    .N_SRC       (N_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sel (
    .clk    (clk),
    .rst    (rst),
    .src_in (src_in),
    .sel    (f.sel),
    .inv    (f.inv),
    .src_q  (src_q)
  );

  clkdiv_core u_core (
    .clk       (clk),
    .rst       (rst),
    .src       (src_q),
    .run       (f.run),
    .ld        (ld_pulse),
    .div_field (f.div),
    .core_out  (core_out)
  );

  assign sel_ok = ({1'b0, f.sel} < NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst) clk_out <= 1'b0;
    else     clk_out <= f.oe & sel_ok & core_out;
  end

  assign rd_data     = ctrl_q;
  assign clk_oe      = f.oe;
  assign clk_present = f.pres;

  // R10: a disabled output is low on the next edge
  a_r10_oe_low: assert property (@(posedge clk) disable iff (rst)
    !clk_oe |=> !clk_out);

  // R11: a reserved source code silences the output
  a_r11_reserved_low: assert property (@(posedge clk) disable iff (rst)
    !sel_ok |=> !clk_out);

  // R1: reserved bits never read back as set
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (rd_data[15:14] == 2'b00));
endmodule

// File: tb/clksrc_divider_tb_top.sv
`timescale 1ns/1ps
module clksrc_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [6:0]  src_in = '0;
  logic        clk_out;
  logic        clk_oe;
  logic        clk_present;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clksrc_divider dut_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .src_in      (src_in),
    .clk_out     (clk_out),
    .clk_oe      (clk_oe),
    .clk_present (clk_present)
  );

  // source k: high for k+1 cycles, low for 7, period k+8
  int ph [7];
  initial for (int k = 0; k < 7; k++) ph[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < 7; k++) begin
      src_in[k] <= (ph[k] < k + 1);
      ph[k]     <= (ph[k] == k + 7) ? 0 : ph[k] + 1;
    end
  end

  function automatic logic [15:0] mk(input logic [5:0] d, input logic ld,
                                     input logic inv, input logic [2:0] sel,
                                     input logic oe, input logic pres,
                                     input logic run);
    return {2'b00, run, pres, oe, sel, inv, ld, d};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_len(input logic v, output int n);
    int g = 0;
    while (clk_out == v && g < 600) begin @(negedge clk); g++; end
    while (clk_out != v && g < 600) begin @(negedge clk); g++; end
    n = 0;
    while (clk_out == v && g < 600) begin n++; @(negedge clk); g++; end
  endtask

  task automatic expect_low(input string tag, input int cycles);
    int hi = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (clk_out) hi++;
    end
    chk(tag, hi, 0);
  endtask

  task automatic meas(input string tag, input int exp_hi, input int exp_lo);
    int h;
    int l;
    run_len(1'b1, h);
    chk({tag, " high"}, h, exp_hi);
    run_len(1'b0, l);
    chk({tag, " low"}, l, exp_lo);
  endtask

  task automatic t_reset();
    chk("R1 reset value", rd_data, 16'h0403);
    chk("R10 reset oe", clk_oe, 0);
    chk("R10 reset out", clk_out, 0);
  endtask

  task automatic t_readback();
    wr(16'hFFFF);
    @(negedge clk);
    chk("R1 readback ones", rd_data, 16'h3FBF);
    chk("R1 present pin", clk_present, 1);
    wr(16'h1234);
    @(negedge clk);
    chk("R1 readback pattern", rd_data, 16'h1234);
  endtask

  task automatic t_passthru();
    wr(mk(6'd0, 0, 0, 3'd0, 1, 0, 1));
    settle(40);
    meas("R3 div0 src0", 1, 7);
    wr(mk(6'd1, 0, 0, 3'd2, 1, 0, 1));
    settle(40);
    meas("R3 div1 src2", 3, 7);
  endtask

  task automatic t_select();
    wr(mk(6'd0, 0, 0, 3'd6, 1, 0, 1));
    settle(40);
    meas("R2 memory clock", 7, 7);
    wr(mk(6'd0, 0, 0, 3'd4, 1, 0, 1));
    settle(40);
    meas("R2 second receive clock", 5, 7);
  endtask

  task automatic t_reserved();
    wr(mk(6'd0, 0, 1, 3'd7, 1, 0, 1));
    settle(10);
    expect_low("R11 reserved code passthrough", 60);
    wr(mk(6'd4, 1, 0, 3'd7, 1, 0, 1));
    settle(10);
    expect_low("R11 reserved code divided", 60);
  endtask

  task automatic t_invert();
    wr(mk(6'd0, 0, 1, 3'd1, 1, 0, 1));
    settle(40);
    meas("R6 inverted src1", 7, 2);
  endtask

  task automatic t_divide_even();
    wr(mk(6'd4, 0, 0, 3'd0, 1, 0, 1));
    settle(120);
    meas("R4 div4 src0", 16, 16);
    wr(mk(6'd2, 0, 0, 3'd3, 1, 0, 1));
    settle(120);
    meas("R4 div2 src3", 11, 11);
  endtask

  task automatic t_divide_odd();
    wr(mk(6'd5, 0, 0, 3'd0, 1, 0, 1));
    settle(120);
    meas("R5 div5 src0", 16, 24);
    wr(mk(6'd3, 0, 0, 3'd0, 1, 0, 1));
    settle(120);
    meas("R5 div3 src0", 8, 16);
  endtask

  // starts on a divide-by-4 of src0, writes divisor 2 four cycles into a high phase
  task automatic switch_in_high(input logic ld, output int h1, output int l1,
                                output int h2);
    int g = 0;
    wr(mk(6'd4, 1, 0, 3'd0, 1, 0, 1));
    settle(120);
    while (clk_out == 1'b1 && g < 600) begin @(negedge clk); g++; end
    while (clk_out == 1'b0 && g < 600) begin @(negedge clk); g++; end
    h1 = 1;
    repeat (3) begin @(negedge clk); h1++; end
    wr_en   = 1'b1;
    wr_data = mk(6'd2, ld, 0, 3'd0, 1, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    h1++;
    g = 0;
    forever begin
      @(negedge clk);
      g++;
      if (!clk_out || g > 600) break;
      h1++;
    end
    l1 = 1;
    g = 0;
    forever begin
      @(negedge clk);
      g++;
      if (clk_out || g > 600) break;
      l1++;
    end
    h2 = 1;
    g = 0;
    forever begin
      @(negedge clk);
      g++;
      if (!clk_out || g > 600) break;
      h2++;
    end
  endtask

  task automatic t_glitchfree();
    int h1;
    int l1;
    int h2;
    switch_in_high(1'b0, h1, l1, h2);
    chk("R7 current high completes", h1, 16);
    chk("R7 current low completes", l1, 16);
    chk("R7 new divisor next period", h2, 8);
  endtask

  task automatic t_loadnow();
    int h1;
    int l1;
    int h2;
    switch_in_high(1'b1, h1, l1, h2);
    chk("R8 high cut short", h1, 8);
    chk("R8 low at new length", l1, 8);
    @(negedge clk);
    chk("R8 pulse bit reads 0", rd_data[6], 0);
  endtask

  task automatic t_hold();
    wr(mk(6'd4, 0, 0, 3'd0, 1, 0, 0));
    settle(10);
    expect_low("R9 divider held", 80);
    wr(mk(6'd4, 0, 0, 3'd0, 1, 0, 1));
    settle(40);
    meas("R9 divider released", 16, 16);
  endtask

  task automatic t_disable();
    wr(mk(6'd0, 0, 0, 3'd6, 0, 0, 1));
    settle(5);
    chk("R10 oe pin low", clk_oe, 0);
    expect_low("R10 output held", 60);
    wr(mk(6'd0, 0, 0, 3'd6, 1, 0, 1));
    @(negedge clk);
    chk("R10 oe pin high", clk_oe, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_passthru();
    t_select();
    t_reserved();
    t_invert();
    t_divide_even();
    t_divide_odd();
    t_glitchfree();
    t_loadnow();
    t_hold();
    t_disable();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule